// File: doc/BRIEF.md
# Scaled Store Address Generator

This block forms the effective address of a byte, halfword or word store in a 32-bit load/store datapath. It also forms the updated base register value that the store may write back. A 4-bit mode field picks three things: the offset source (a register value or a 5-bit unsigned constant), whether the offset is added to or subtracted from the base, and whether the base is left alone, modified before the access or modified after it. Before it is applied, the offset is scaled by the access size: not shifted for bytes, shifted left by one for halfwords and by two for words.

The results are registered and appear one clock cycle after an input strobe. They are the memory address, four little-endian byte-lane strobes, a store-valid, the new base value with its write-back enable, an alignment-fault flag and an illegal-encoding flag. Three conditions suppress both the memory write and the base write-back: a false condition flag, a misaligned address and an unlisted encoding. The register file and the memory itself are outside this block.

Top module: `ssag_top`

## Requirements
- R1: The size field uses 3'b011 for a byte, 3'b101 for a halfword and 3'b111 for a word. The selected offset is shifted left by 0, 1 or 2 bits respectively before it is used.
- R2: Mode bit 2 selects the offset source. A 1 takes the 32-bit offset register and a 0 takes the zero-extended 5-bit constant. The unselected source has no effect on any output.
- R3: Modes 0101 and 0001 give address = base + scaled offset, and modes 0100 and 0000 give address = base - scaled offset. In these modes write-back stays low.
- R4: Modes 1101 and 1001 (add) and modes 1100 and 1000 (subtract) drive both the address and the new base with the modified base, and they assert write-back.
- R5: Modes 1111 and 1011 (add) and modes 1110 and 1010 (subtract) drive the address with the unmodified base and the new base with the modified base, and they assert write-back.
- R6: The strobe is 4 bits with bit i for byte lane i. A byte store sets only bit address[1:0]. A halfword store gives 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. A word store gives 4'b1111. The strobe is 4'b0000 whenever store-valid is low.
- R7: A word address with bits [1:0] not zero, or a halfword address with bit 0 set, raises the alignment fault. In that case store-valid, write-back and the strobe stay low.
- R8: With the condition flag low, store-valid, write-back, the strobe and both fault flags stay low.
- R9: Mode encodings 0010, 0011, 0110 and 0111, and any size value other than the three listed, raise the illegal flag. Store-valid, write-back, the strobe and the alignment fault then stay low.
- R10: Address and new-base arithmetic wraps modulo 2^32.
- R11: Outputs are registered and reflect the inputs one clock cycle after an input strobe. In a cycle without a strobe, the next cycle's store-valid, write-back, strobe and flags are low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe: fields below are meaningful |
| cond_ok | input | 1 | Store condition; low turns the store into a no-op |
| mode | input | 4 | Addressing mode field |
| size | input | 3 | Access size field |
| base | input | 32 | Base register value |
| off_reg | input | 32 | Offset register value |
| off_cst | input | 5 | Unsigned constant offset |
| mem_addr | output | 32 | Effective store address |
| mem_strb | output | 4 | Byte-lane write strobes |
| store_vld | output | 1 | Memory write takes place |
| new_base | output | 32 | Modified base value |
| base_wb | output | 1 | Base write-back enable |
| align_fault | output | 1 | Misaligned effective address |
| illegal | output | 1 | Unlisted mode or size encoding |

## Verification
The checker watches several properties on every cycle. It confirms that no fault, false condition or idle cycle ever lets a write or write-back through. It confirms that the strobe is empty without a store and full for every word store, that stored words are aligned, and that post-modify stores use the previous base as their address. The arithmetic itself cannot be seen by a property without restating it: the value of a scaled sum or difference, the wrap past zero, which offset source was taken and which byte lane was chosen. Only the bench's vectors with precomputed results show those.

// File: rtl/ssag_pkg.sv
package ssag_pkg;
    localparam logic [2:0] SZ_BYTE = 3'b011;
    localparam logic [2:0] SZ_HALF = 3'b101;
    localparam logic [2:0] SZ_WORD = 3'b111;

    localparam int MB_UP   = 0;
    localparam int MB_POST = 1;
    localparam int MB_REG  = 2;
    localparam int MB_MOD  = 3;

    function automatic logic [1:0] size_shift(input logic [2:0] sz);
        case (sz)
            SZ_HALF: size_shift = 2'd1;
            SZ_WORD: size_shift = 2'd2;
            default: size_shift = 2'd0;
        endcase
    endfunction

    function automatic logic size_known(input logic [2:0] sz);
        size_known = (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
    endfunction
endpackage

// File: rtl/ssag_scale.sv
module ssag_scale #(
    parameter int XLEN = 32,
    parameter int CW   = 5
) (
    input  logic [XLEN-1:0] off_reg,
    input  logic [CW-1:0]   off_cst,
    input  logic            use_reg,
    input  logic [1:0]      shamt,
    output logic [XLEN-1:0] scaled
);
    logic [XLEN-1:0] raw;

    always_comb begin
        raw    = use_reg ? off_reg : {{(XLEN-CW){1'b0}}, off_cst};
        scaled = raw << shamt;
    end
endmodule

// File: rtl/ssag_addsub.sv
module ssag_addsub #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] scaled,
    input  logic            up,
    input  logic            post,
    output logic [XLEN-1:0] modified,
    output logic [XLEN-1:0] eff
);
    always_comb begin
        modified = up ? (base + scaled) : (base - scaled);
        eff      = post ? base : modified;
    end
endmodule

// File: rtl/ssag_lanes.sv
module ssag_lanes #(
    parameter int LANES = 4
) (
    input  logic [$clog2(LANES)-1:0] addr_lo,
    input  logic [2:0]               size,
    output logic [LANES-1:0]         strb,
    output logic                     misaligned
);
    import ssag_pkg::*;
    localparam int AW = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [AW-1:0] IDX = AW'(i);
        always_comb begin
            case (size)
                SZ_WORD: strb[i] = 1'b1;
                SZ_HALF: strb[i] = (addr_lo[AW-1:1] == IDX[AW-1:1]);
                default: strb[i] = (addr_lo == IDX);
            endcase
        end
    end

    always_comb begin
        case (size)
            SZ_WORD: misaligned = (addr_lo[1:0] != 2'b00);
            SZ_HALF: misaligned = addr_lo[0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/ssag_top.sv
module ssag_top #(
    parameter int XLEN  = 32,
    parameter int CW    = 5,
    parameter int LANES = XLEN / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             cond_ok,
    input  logic [3:0]       mode,
    input  logic [2:0]       size,
    input  logic [XLEN-1:0]  base,
    input  logic [XLEN-1:0]  off_reg,
    input  logic [CW-1:0]    off_cst,
    output logic [XLEN-1:0]  mem_addr,
    output logic [LANES-1:0] mem_strb,
    output logic             store_vld,
    output logic [XLEN-1:0]  new_base,
    output logic             base_wb,
    output logic             align_fault,
    output logic             illegal
);
    import ssag_pkg::*;
    localparam int AW = $clog2(LANES);

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  nbase;
        logic [LANES-1:0] strb;
        logic             st;
        logic             wb;
        logic             af;
        logic             il;
    } out_t;

    out_t state_d, state_q;

    logic [1:0]       shamt;
    logic [XLEN-1:0]  scaled;
    logic [XLEN-1:0]  modified;
    logic [XLEN-1:0]  eff;
    logic [LANES-1:0] lane_strb;
    logic             misaligned;
    logic             legal;

    always_comb begin
        shamt = size_shift(size);
        legal = size_known(size) && (mode[MB_MOD] || !mode[MB_POST]);
    end

    ssag_scale #(.XLEN(XLEN), .CW(CW)) u_scale (
        .off_reg (off_reg),
        .off_cst (off_cst),
        .use_reg (mode[MB_REG]),
        .shamt   (shamt),
        .scaled  (scaled)
    );

    ssag_addsub #(.XLEN(XLEN)) u_addsub (
        .base     (base),
        .scaled   (scaled),
        .up       (mode[MB_UP]),
        .post     (mode[MB_MOD] && mode[MB_POST]),
        .modified (modified),
        .eff      (eff)
    );

    ssag_lanes #(.LANES(LANES)) u_lanes (
        .addr_lo    (eff[AW-1:0]),
        .size       (size),
        .strb       (lane_strb),
        .misaligned (misaligned)
    );

    always_comb begin
        state_d      = state_q;
        state_d.strb = '0;
        state_d.st   = 1'b0;
        state_d.wb   = 1'b0;
        state_d.af   = 1'b0;
        state_d.il   = 1'b0;
        if (in_valid) begin
            state_d.addr  = eff;
            state_d.nbase = modified;
            if (cond_ok) begin
                if (!legal) begin
                    state_d.il = 1'b1;
                end else if (misaligned) begin
                    state_d.af = 1'b1;
                end else begin
                    state_d.st   = 1'b1;
                    state_d.wb   = mode[MB_MOD];
                    state_d.strb = lane_strb;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mem_addr    = state_q.addr;
    assign new_base    = state_q.nbase;
    assign mem_strb    = state_q.strb;
    assign store_vld   = state_q.st;
    assign base_wb     = state_q.wb;
    assign align_fault = state_q.af;
    assign illegal     = state_q.il;
endmodule

// File: rtl/ssag_checker.sv
module ssag_checker #(
    parameter int XLEN  = 32,
    parameter int CW    = 5,
    parameter int LANES = XLEN / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             cond_ok,
    input logic [3:0]       mode,
    input logic [2:0]       size,
    input logic [XLEN-1:0]  base,
    input logic [XLEN-1:0]  off_reg,
    input logic [CW-1:0]    off_cst,
    input logic [XLEN-1:0]  mem_addr,
    input logic [LANES-1:0] mem_strb,
    input logic             store_vld,
    input logic [XLEN-1:0]  new_base,
    input logic             base_wb,
    input logic             align_fault,
    input logic             illegal
);
    logic seen_edge;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    assert_empty_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !store_vld |-> mem_strb == '0);

    assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!store_vld && !base_wb));

    assert_illegal_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!store_vld && !base_wb && !align_fault));

    assert_cond_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_ok) |=> (!store_vld && !base_wb && !align_fault && !illegal));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!store_vld && !base_wb && !illegal));

    assert_word_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && in_valid && size == 3'b111) |=> (!store_vld || mem_strb == '1));

    assert_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && mem_strb == '1) |-> mem_addr[1:0] == 2'b00);

    assert_post_uses_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[3] && mode[1]) |=> (!store_vld || mem_addr == $past(base)));

    assert_plain_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode[3]) |=> !base_wb);
endmodule

bind ssag_top ssag_checker #(.XLEN(XLEN), .CW(CW), .LANES(LANES)) u_checker (.*);

// File: tb/ssag_top_test.sv
module ssag_top_test;
    typedef struct packed {
        logic [31:0] base;
        logic [31:0] offr;
        logic [4:0]  cst;
        logic [3:0]  mode;
        logic [2:0]  size;
        logic        cond;
        logic [31:0] e_addr;
        logic [3:0]  e_strb;
        logic [31:0] e_nb;
        logic        e_wb;
        logic        e_st;
        logic        e_af;
        logic        e_il;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 32'h3,         5'd31, 4'b0101, 3'b111, 1'b1, 32'h0000_100C, 4'b1111, 32'h0000_100C, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_1000, 32'h4,         5'd0,  4'b0100, 3'b111, 1'b1, 32'h0000_0FF0, 4'b1111, 32'h0000_0FF0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_2000, 32'h0,         5'd7,  4'b0001, 3'b011, 1'b1, 32'h0000_2007, 4'b1000, 32'h0000_2007, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_2000, 32'h0,         5'd3,  4'b0000, 3'b101, 1'b1, 32'h0000_1FFA, 4'b1100, 32'h0000_1FFA, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0100, 32'h1,         5'd0,  4'b1101, 3'b111, 1'b1, 32'h0000_0104, 4'b1111, 32'h0000_0104, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0100, 32'h0,         5'd2,  4'b1000, 3'b101, 1'b1, 32'h0000_00FC, 4'b0011, 32'h0000_00FC, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0200, 32'h2,         5'd0,  4'b1111, 3'b111, 1'b1, 32'h0000_0200, 4'b1111, 32'h0000_0208, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0201, 32'h0,         5'd1,  4'b1010, 3'b011, 1'b1, 32'h0000_0201, 4'b0010, 32'h0000_0200, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0000_1002, 32'h0,         5'd0,  4'b0101, 3'b111, 1'b1, 32'h0000_1002, 4'b0000, 32'h0000_1002, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_0101, 32'h0,         5'd0,  4'b1001, 3'b101, 1'b1, 32'h0000_0101, 4'b0000, 32'h0000_0101, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_0300, 32'h5,         5'd0,  4'b0110, 3'b111, 1'b1, 32'h0000_02EC, 4'b0000, 32'h0000_02EC, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0000_0400, 32'h1,         5'd0,  4'b1101, 3'b111, 1'b0, 32'h0000_0404, 4'b0000, 32'h0000_0404, 1'b0, 1'b0, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h1,         5'd9,  4'b1100, 3'b111, 1'b1, 32'hFFFF_FFFC, 4'b1111, 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'hFFFF_FFF0, 32'h0,         5'd31, 4'b0001, 3'b011, 1'b1, 32'h0000_000F, 4'b1000, 32'h0000_000F, 1'b0, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0500, 32'h1,         5'd0,  4'b0101, 3'b100, 1'b1, 32'h0000_0501, 4'b0000, 32'h0000_0501, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0000_0600, 32'h0000_FFFF, 5'd2,  4'b0001, 3'b111, 1'b1, 32'h0000_0608, 4'b1111, 32'h0000_0608, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 3: tag_of = "R3 R1 R6";
            4, 5:       tag_of = "R4";
            6, 7:       tag_of = "R5";
            8, 9:       tag_of = "R7";
            10, 14:     tag_of = "R9";
            11:         tag_of = "R8";
            12, 13:     tag_of = "R10";
            default:    tag_of = "R2";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        cond_ok = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  size = '0;
    logic [31:0] base = '0;
    logic [31:0] off_reg = '0;
    logic [4:0]  off_cst = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_strb;
    logic        store_vld;
    logic [31:0] new_base;
    logic        base_wb;
    logic        align_fault;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ssag_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_ok(cond_ok),
        .mode(mode), .size(size), .base(base), .off_reg(off_reg), .off_cst(off_cst),
        .mem_addr(mem_addr), .mem_strb(mem_strb), .store_vld(store_vld),
        .new_base(new_base), .base_wb(base_wb), .align_fault(align_fault),
        .illegal(illegal)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        base = v.base; off_reg = v.offr; off_cst = v.cst;
        mode = v.mode; size = v.size; cond_ok = v.cond; in_valid = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset clears every output
        check("R11", "reset addr", mem_addr, 32'h0);
        check("R11", "reset nbase", new_base, 32'h0);
        check("R11", "reset ctl", {27'd0, mem_strb, store_vld}, 32'h0);
        check("R11", "reset flags", {29'd0, base_wb, align_fault, illegal}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            check(tag_of(i), "addr", mem_addr, VEC[i].e_addr);
            check(tag_of(i), "strb", {28'd0, mem_strb}, {28'd0, VEC[i].e_strb});
            check(tag_of(i), "nbase", new_base, VEC[i].e_nb);
            check(tag_of(i), "wb", {31'd0, base_wb}, {31'd0, VEC[i].e_wb});
            check(tag_of(i), "st", {31'd0, store_vld}, {31'd0, VEC[i].e_st});
            check(tag_of(i), "af", {31'd0, align_fault}, {31'd0, VEC[i].e_af});
            check(tag_of(i), "il", {31'd0, illegal}, {31'd0, VEC[i].e_il});
        end

        // R11: a strobe-free cycle after a write-back store yields nothing
        apply(VEC[4]);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R11", "idle st", {31'd0, store_vld}, 32'h0);
        check("R11", "idle wb", {31'd0, base_wb}, 32'h0);
        check("R11", "idle strb", {28'd0, mem_strb}, 32'h0);

        // R2 / R6: register source ignores the constant; every byte lane reachable
        for (int k = 0; k < 4; k++) begin
            base = 32'h0000_0700; off_reg = 32'(k); off_cst = 5'd17;
            mode = 4'b0101; size = 3'b011; cond_ok = 1'b1; in_valid = 1'b1;
            @(negedge clk);
            check("R2", "reg src addr", mem_addr, 32'h0000_0700 + 32'(k));
            check("R6", "byte lane", {28'd0, mem_strb}, 32'(1 << k));
        end

        // R7: word at address with bit0 set only (offset 1 word from 0x...1)
        base = 32'h0000_0801; off_cst = 5'd1; mode = 4'b1011; size = 3'b111;
        @(negedge clk);
        check("R7", "post misalign af", {31'd0, align_fault}, 32'h1);
        check("R7", "post misalign wb", {31'd0, base_wb}, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule